// File: doc/BRIEF.md
# Receive Frame Length Limiter

This block sits between an infrared receive front end and a tagged receive FIFO. The front end delivers deserialized bytes together with a start-of-frame strobe and an end-of-frame strobe. The block writes each data byte into the FIFO in the same cycle it arrives. It counts the bytes of the current frame and refuses to store more than a programmable maximum. When the frame ends, it appends the frame's CRC bytes. Two or four CRC bytes are written, as selected. The last of these carries a tag that marks end of frame and holds the frame's status: CRC error, length error and overrun.

On the read side, the block watches the entry that leaves the FIFO head. When an end-of-frame entry is popped, its status bits are copied into a line status register. This register holds until the next tagged entry reaches the head. CRC checking and line decoding are done elsewhere. The CRC verdict and the CRC value arrive as inputs, sampled with the end-of-frame strobe.

The control is a three-state machine. ST_IDLE waits for a frame. ST_DATA stores data bytes. ST_CRC writes the CRC bytes, one per cycle, and waits while the FIFO is full. The transitions are named as follows. T_START goes from ST_IDLE to ST_DATA on a start strobe. T_RESTART stays in ST_DATA on a new start strobe. T_END goes from ST_IDLE or ST_DATA to ST_CRC on an end strobe inside a frame. T_DONE goes from ST_CRC to ST_IDLE once the last CRC byte is written.

Top module: `rx_len_limiter`

## Requirements
- R1: A start strobe clears the frame byte counter, so each frame gets its full allowance again. A byte that arrives together with the start strobe counts as that frame's first byte.
- R2: Inside a frame, an accepted data byte raises `fifo_wr` combinationally in the cycle it is presented, with tag 0. Bytes and end strobes presented in ST_IDLE without a start strobe write nothing.
- R3: When `max_len` is nonzero, at most `max_len` data bytes of a frame are written. Later bytes are dropped. A `max_len` of 0 removes the limit.
- R4: The length error bit of the frame tag is 1 exactly when the frame had more than `max_len` data bytes, with `max_len` nonzero.
- R5: After an end strobe, the CRC bytes follow the data bytes: four when `crc_wide` is 1, otherwise two. They are taken from `crc_value`, least significant byte first, sampled with the end strobe. One is written in each cycle in which `fifo_full` is low, starting the cycle after the end strobe.
- R6: Tag format, LSB first: bit 0 end of frame, bit 1 CRC error (`crc_err` sampled with the end strobe), bit 2 length error, bit 3 overrun. Only the last CRC byte carries a nonzero tag.
- R7: A data byte within the limit that meets `fifo_full` high is dropped and sets the frame's overrun bit. `fifo_wr` is never high while `fifo_full` is high.
- R8: One cycle after `head_pop` with `head_tag` bit 0 set, `lsr_status` = {overrun, length error, CRC error} from `head_tag` bits 3..1. Otherwise it holds. It resets to 0.
- R9: `drain_busy` is high exactly in ST_CRC. In that state, start strobes, bytes and end strobes have no effect.
- R10: A start strobe inside a frame abandons the frame. Its bytes already written stay untagged, and its status bits are cleared for the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| max_len | input | 13 | Maximum data bytes per frame, 0 = unlimited |
| crc_wide | input | 1 | 1 = four CRC bytes, 0 = two |
| rx_sof | input | 1 | Start-of-frame strobe |
| rx_byte_vld | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame strobe |
| crc_err | input | 1 | CRC check failed, valid with `rx_eof` |
| crc_value | input | 32 | Received CRC, valid with `rx_eof` |
| fifo_full | input | 1 | Receive FIFO has no free entry |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write byte |
| fifo_wtag | output | 4 | FIFO write tag |
| drain_busy | output | 1 | CRC bytes being written |
| head_pop | input | 1 | FIFO head entry consumed |
| head_tag | input | 4 | Tag of the FIFO head entry |
| lsr_status | output | 3 | Line status {overrun, length error, CRC error} |

## Verification
The write strobe, byte and tag depend combinationally on the current inputs and state. The bench drives at the falling edge and samples them 8 ns later, before the rising edge that commits them. CRC byte k appears in the k-th non-full cycle after the end-strobe cycle. `drain_busy` is read 5 ns after each falling edge in that window. The line status is due one edge after the pop, so it is checked in the following low phase. Every write is captured and compared in order against a stream that bench functions predict from the requirements.

// File: rtl/rxll_pkg.sv
package rxll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CRC  = 2'd2
    } rxll_state_e;

    typedef struct packed {
        logic ovr;
        logic len_err;
        logic crc_err;
        logic eof;
    } rx_tag_t;

endpackage

// File: rtl/rxll_len_ctr.sv
module rxll_len_ctr #(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LEN_W-1:0] limit,
    output logic             at_limit
);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] cnt_eff;

    // A start strobe makes this cycle's byte the first of the frame.
    assign cnt_eff  = clr ? '0 : cnt_q;
    assign at_limit = (limit != '0) && (cnt_eff >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || inc) begin
            if (inc && cnt_eff != CNT_MAX) begin
                cnt_q <= cnt_eff + LEN_W'(1);
            end else begin
                cnt_q <= cnt_eff;
            end
        end
    end
endmodule

// File: rtl/rxll_crc_sel.sv
module rxll_crc_sel #(
    parameter int CRC_BYTES = 4,
    parameter int IDX_W     = 2
) (
    input  logic [CRC_BYTES*8-1:0] crc_val,
    input  logic [IDX_W-1:0]       idx,
    output logic [7:0]             crc_byte
);
    logic [7:0] lane [CRC_BYTES];

    for (genvar gi = 0; gi < CRC_BYTES; gi++) begin : g_lane
        assign lane[gi] = crc_val[gi*8 +: 8];
    end

    always_comb begin
        crc_byte = lane[0];
        for (int i = 0; i < CRC_BYTES; i++) begin
            if (idx == IDX_W'(i)) begin
                crc_byte = lane[i];
            end
        end
    end
endmodule

// File: rtl/rxll_lsr.sv
module rxll_lsr
    import rxll_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pop,
    input  rx_tag_t tag,
    output logic [2:0] status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else if (pop && tag.eof) begin
            status <= {tag.ovr, tag.len_err, tag.crc_err};
        end
    end
endmodule

// File: rtl/rx_len_limiter.sv
module rx_len_limiter
    import rxll_pkg::*;
#(
    parameter int LEN_W     = 13,
    parameter int CRC_BYTES = 4,
    parameter int CRC_SHORT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LEN_W-1:0]       max_len,
    input  logic                   crc_wide,
    input  logic                   rx_sof,
    input  logic                   rx_byte_vld,
    input  logic [7:0]             rx_byte,
    input  logic                   rx_eof,
    input  logic                   crc_err,
    input  logic [CRC_BYTES*8-1:0] crc_value,
    input  logic                   fifo_full,
    output logic                   fifo_wr,
    output logic [7:0]             fifo_wdata,
    output logic [3:0]             fifo_wtag,
    output logic                   drain_busy,
    input  logic                   head_pop,
    input  logic [3:0]             head_tag,
    output logic [2:0]             lsr_status
);
    localparam int IDX_W = (CRC_BYTES > 1) ? $clog2(CRC_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(CRC_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(CRC_SHORT - 1);

    rxll_state_e state_q, state_d;

    logic                   crc_err_q, len_err_q, ovr_q, crc_wide_q;
    logic [CRC_BYTES*8-1:0] crc_val_q;
    logic [IDX_W-1:0]       crc_idx_q;

    logic    sof_ok, in_frame, end_now, at_limit, take, crc_last;
    logic [7:0] crc_byte;
    rx_tag_t last_tag;

    // Start strobes are honoured everywhere except during the CRC drain.
    assign sof_ok   = rx_sof && (state_q != ST_CRC);
    assign in_frame = (state_q == ST_DATA) || sof_ok;
    assign end_now  = in_frame && rx_eof;
    assign take     = in_frame && rx_byte_vld && !at_limit;
    assign crc_last = crc_idx_q == (crc_wide_q ? LAST_LONG : LAST_SHORT);

    assign last_tag = '{ovr: ovr_q, len_err: len_err_q, crc_err: crc_err_q, eof: 1'b1};

    rxll_len_ctr #(.LEN_W(LEN_W)) u_len_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sof_ok),
        .inc      (in_frame && rx_byte_vld),
        .limit    (max_len),
        .at_limit (at_limit)
    );

    rxll_crc_sel #(.CRC_BYTES(CRC_BYTES), .IDX_W(IDX_W)) u_crc_sel (
        .crc_val  (crc_val_q),
        .idx      (crc_idx_q),
        .crc_byte (crc_byte)
    );

    rxll_lsr u_lsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop    (head_pop),
        .tag    (rx_tag_t'(head_tag)),
        .status (lsr_status)
    );

    // Next state: T_START, T_RESTART, T_END, T_DONE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (end_now)     state_d = ST_CRC;   // T_END (empty frame)
                else if (sof_ok) state_d = ST_DATA;  // T_START
            end
            ST_DATA: begin
                if (end_now)     state_d = ST_CRC;   // T_END
                else             state_d = ST_DATA;  // T_RESTART on sof
            end
            ST_CRC: begin
                if (!fifo_full && crc_last) state_d = ST_IDLE; // T_DONE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Frame status and CRC capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_err_q  <= 1'b0;
            len_err_q  <= 1'b0;
            ovr_q      <= 1'b0;
            crc_wide_q <= 1'b0;
            crc_val_q  <= '0;
            crc_idx_q  <= '0;
        end else begin
            if (sof_ok) begin
                len_err_q <= rx_byte_vld && at_limit;
                ovr_q     <= take && fifo_full;
            end else if (state_q == ST_DATA) begin
                len_err_q <= len_err_q | (rx_byte_vld && at_limit);
                ovr_q     <= ovr_q | (take && fifo_full);
            end
            if (end_now) begin
                crc_err_q  <= crc_err;
                crc_wide_q <= crc_wide;
                crc_val_q  <= crc_value;
                crc_idx_q  <= '0;
            end else if (state_q == ST_CRC && !fifo_full) begin
                crc_idx_q <= crc_idx_q + IDX_W'(1);
            end
        end
    end

    // Outputs.
    always_comb begin
        fifo_wr    = 1'b0;
        fifo_wdata = rx_byte;
        fifo_wtag  = '0;
        drain_busy = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DATA: begin
                fifo_wr = take && !fifo_full;
            end
            ST_CRC: begin
                drain_busy = 1'b1;
                fifo_wr    = !fifo_full;
                fifo_wdata = crc_byte;
                fifo_wtag  = crc_last ? last_tag : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rx_len_limiter_chk.sv
module rx_len_limiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_full,
    input logic       fifo_wr,
    input logic [3:0] fifo_wtag,
    input logic       drain_busy,
    input logic       head_pop,
    input logic [3:0] head_tag,
    input logic [2:0] lsr_status
);
    assert_no_write_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);

    assert_tag_only_on_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !fifo_wtag[0]) |-> (fifo_wtag[3:1] == 3'b000));

    assert_drain_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_busy && fifo_full) |=> drain_busy);

    assert_lsr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (head_pop && head_tag[0]) |=> (lsr_status == $past(head_tag[3:1])));

    assert_lsr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(head_pop && head_tag[0]) |=> $stable(lsr_status));
endmodule

bind rx_len_limiter rx_len_limiter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_full  (fifo_full),
    .fifo_wr    (fifo_wr),
    .fifo_wtag  (fifo_wtag),
    .drain_busy (drain_busy),
    .head_pop   (head_pop),
    .head_tag   (head_tag),
    .lsr_status (lsr_status)
);

// File: tb/rx_len_limiter_bench.sv
module rx_len_limiter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] max_len;
    logic        crc_wide, rx_sof, rx_byte_vld, rx_eof, crc_err, fifo_full;
    logic [7:0]  rx_byte;
    logic [31:0] crc_value;
    logic        fifo_wr, drain_busy, head_pop;
    logic [7:0]  fifo_wdata;
    logic [3:0]  fifo_wtag, head_tag;
    logic [2:0]  lsr_status;

    int n_chk = 0;
    int n_err = 0;
    logic [11:0] exp_q[$];
    logic [11:0] got_q[$];
    int m_cnt;
    bit m_len, m_ovr;

    always #10 clk = ~clk;

    rx_len_limiter u_rx_len_limiter (
        .clk(clk), .rst_n(rst_n), .max_len(max_len), .crc_wide(crc_wide),
        .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .rx_eof(rx_eof), .crc_err(crc_err), .crc_value(crc_value),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_wtag(fifo_wtag), .drain_busy(drain_busy), .head_pop(head_pop),
        .head_tag(head_tag), .lsr_status(lsr_status)
    );

    // Capture every write just before the edge that commits it.
    always @(negedge clk) begin
        #8;
        if (rst_n && fifo_wr) got_q.push_back({fifo_wtag, fifo_wdata});
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_tag(input bit ovr, input bit len, input bit cerr);
        return {ovr, len, cerr, 1'b1};
    endfunction

    function automatic bit pick(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    task automatic drive(input bit s, input bit v, input logic [7:0] d, input bit e, input bit f);
        @(negedge clk);
        rx_sof = s; rx_byte_vld = v; rx_byte = d; rx_eof = e; fifo_full = f;
        if (s) begin m_cnt = 0; m_len = 0; m_ovr = 0; end
        if (v) begin
            if (max_len != 0 && m_cnt >= int'(max_len)) m_len = 1;
            else if (f) m_ovr = 1;
            else exp_q.push_back({4'h0, d});
            m_cnt++;
        end
    endtask

    task automatic drain(input int full_pct, input bit cerr, input bit wide, input logic [31:0] cv);
        int n = wide ? 4 : 2;
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            // Stray inputs during the drain must be ignored (R9).
            rx_sof = pick(30); rx_byte_vld = pick(50); rx_byte = 8'($urandom);
            rx_eof = pick(30);
            fifo_full = pick(full_pct);
            #5;
            chk(drain_busy === 1'b1, "R9 busy during drain", drain_busy, 1);
            if (!fifo_full) begin
                exp_q.push_back({(k == n - 1) ? exp_tag(m_ovr, m_len, cerr) : 4'h0, cv[k*8 +: 8]});
                k++;
            end
        end
        @(negedge clk);
        rx_sof = 0; rx_byte_vld = 0; rx_eof = 0; fifo_full = 0;
        #5;
        chk(drain_busy === 1'b0, "R9 idle after drain", drain_busy, 0);
        #4;
    endtask

    task automatic compare(input string req);
        chk(got_q.size() == exp_q.size(), {req, " write count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] === exp_q[i], {req, " entry"}, got_q[i], exp_q[i]);
        exp_q.delete();
        got_q.delete();
    endtask

    task automatic run_frame(input int nb, input int gap_pct, input int full_pct, input bit wide,
                             input bit cerr, input bit eof_last, input bit keep, input string req);
        logic [31:0] cv = $urandom;
        int sent = 0;
        bit first = 1;
        if (!keep) begin exp_q.delete(); got_q.delete(); end
        crc_wide = wide; crc_err = cerr; crc_value = cv;
        if (nb == 0) drive(1, 0, 8'h00, 0, pick(full_pct));
        while (sent < (eof_last ? nb - 1 : nb)) begin
            bit v = first ? pick(50) : !pick(gap_pct);
            drive(first, v, 8'($urandom), 0, pick(full_pct));
            if (v) sent++;
            first = 0;
        end
        if (eof_last && nb > 0) drive(first, 1, 8'($urandom), 1, pick(full_pct));
        else drive(0, 0, 8'h00, 1, 0);
        drain(full_pct, cerr, wide, cv);
        compare(req);
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 0; max_len = 0; crc_wide = 0; rx_sof = 0; rx_byte_vld = 0; rx_byte = 0;
        rx_eof = 0; crc_err = 0; crc_value = 0; fifo_full = 0; head_pop = 0; head_tag = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #5;
        chk(lsr_status === 3'b000, "R8 reset status", lsr_status, 0);
        chk(fifo_wr === 1'b0, "R2 reset no write", fifo_wr, 0);
        chk(drain_busy === 1'b0, "R9 reset idle", drain_busy, 0);

        // R2: bytes and end strobes outside a frame write nothing.
        exp_q.delete(); got_q.delete();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); rx_byte_vld = 1; rx_byte = 8'(i); rx_eof = (i == 3);
        end
        @(negedge clk); rx_byte_vld = 0; rx_eof = 0; #9;
        chk(got_q.size() == 0, "R2 idle bytes ignored", got_q.size(), 0);
        chk(drain_busy === 1'b0, "R2 idle eof ignored", drain_busy, 0);

        // R3 R4: exact limit, over limit, unlimited.
        max_len = 5;
        run_frame(5, 0, 0, 1, 0, 0, 0, "R3 R4 exact limit");
        run_frame(9, 20, 0, 0, 1, 0, 0, "R3 R4 over limit");
        max_len = 0;
        run_frame(30, 10, 0, 1, 0, 0, 0, "R3 unlimited");
        // R1: after an over-limit frame the counter restarts.
        max_len = 4;
        run_frame(7, 0, 0, 0, 0, 0, 0, "R4 long frame");
        run_frame(4, 0, 0, 0, 0, 0, 0, "R1 counter restart");
        // R5: two and four CRC bytes, with stalls.
        run_frame(3, 0, 0, 0, 1, 0, 0, "R5 short crc");
        run_frame(3, 0, 0, 1, 1, 0, 0, "R5 wide crc");
        run_frame(2, 0, 60, 1, 0, 0, 0, "R5 R7 stalled drain");
        // R7: overrun during data.
        max_len = 0;
        run_frame(12, 0, 40, 0, 0, 0, 0, "R7 overrun");
        // R6: end strobe with last byte, and an empty frame.
        run_frame(4, 0, 0, 1, 1, 1, 0, "R6 eof with last byte");
        run_frame(0, 0, 0, 0, 1, 0, 0, "R6 empty frame");

        // R10: start strobe mid-frame abandons the frame.
        max_len = 3;
        exp_q.delete(); got_q.delete();
        drive(1, 1, 8'hA1, 0, 0);
        drive(0, 1, 8'hA2, 0, 1);
        drive(0, 1, 8'hA3, 0, 0);
        run_frame(3, 0, 0, 0, 0, 0, 1, "R10 restart mid frame");

        // Random frames.
        for (int f = 0; f < 40; f++) begin
            max_len = 13'($urandom % 10);
            run_frame(int'($urandom % 14), 25, 15, bit'($urandom % 2), bit'($urandom % 2),
                      bit'($urandom % 2), 0, "R3 R4 R5 R6 R7 random");
        end

        // R8: line status capture.
        @(negedge clk); head_pop = 1; head_tag = 4'b1011;
        @(negedge clk); head_pop = 0; head_tag = 4'b0000; #5;
        chk(lsr_status === 3'b101, "R8 load", lsr_status, 3'b101);
        @(negedge clk); head_pop = 1; head_tag = 4'b0110;
        @(negedge clk); head_pop = 0; #5;
        chk(lsr_status === 3'b101, "R8 untagged pop holds", lsr_status, 3'b101);
        @(negedge clk); head_pop = 0; head_tag = 4'b0101;
        @(negedge clk); #5;
        chk(lsr_status === 3'b101, "R8 no pop holds", lsr_status, 3'b101);
        @(negedge clk); head_pop = 1; head_tag = 4'b0101;
        @(negedge clk); head_pop = 0; #5;
        chk(lsr_status === 3'b010, "R8 reload", lsr_status, 3'b010);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule